// File: doc/BRIEF.md
# Direct-Register Host Mailbox and FIFO Interface

This block sits between a host bus and a local controller. It provides a pair of FIFOs, one in each direction, and a pair of small mailboxes. Every host-visible register is reached in one access at a fixed offset; there is no index register. The host moves bulk traffic through a data port. The data port works with byte accesses or, in word mode, with 16-bit accesses. The host polls a status register and programs a write-only enable register. It exchanges short 6-bit messages through the mailbox register.

The local side pushes entries into the inbound FIFO and pops entries from the outbound FIFO. It writes the inbound mailbox and reads the outbound mailbox, and it alone can open the global interrupt gate. The FIFO storage holds 2^AW entries. The usable capacity is the full depth in word mode and half of it in byte mode. A host write to the reset offset returns the board side to its initial state. The level interrupt output reflects the enabled status conditions while the gate is open.

Top module: `mbf_host_if`

## Requirements
- R1: Host offsets: 0 is the data port, 2 reads status and writes the enable register, 3 is the mailbox, and a write to 7 is a board reset. A read of offset 7 returns 0 and changes nothing. A byte write to offset 1 has no effect.
- R2: Each mailbox stores only bits 7:2 of a write. Bits 1:0 always read as zero, on the host side and on the local side.
- R3: Status bits, each a live level: bit7 outbound mailbox unread, bit6 outbound full, bit5 inbound empty, bit4 outbound at least half full, bit3 inbound at least half full, bit2 inbound mailbox holds data, bit1 inbound full, bit0 outbound empty. After reset the status reads 0x21.
- R4: Enable register bits: bit7 mailbox readback select, bit6 inbound-mailbox interrupt, bit5 inbound-full, bit3 inbound-empty, bit2 outbound-full, bit0 outbound-empty. Bits 4 and 1 are forced to zero and enable nothing.
- R5: With bit7 of the enable register clear, a mailbox read returns the inbound mailbox. With it set, the read returns the outbound mailbox and leaves the inbound flag alone.
- R6: A host mailbox write sets status bit7. A host readback leaves it set. A local read of the outbound mailbox clears it.
- R7: A local mailbox write sets status bit2. A host read of the inbound mailbox with the select bit clear clears it.
- R8: FIFO capacity is 2^AW entries in word mode and 2^(AW-1) in byte mode. A push into a full FIFO is dropped.
- R9: In word mode a 16-bit access moves one entry: bits 7:0 are the offset-0 byte and bits 15:8 the offset-1 byte. A byte read of the data port returns the low byte and still consumes the entry. In byte mode only bits 7:0 are carried and the upper byte is zero.
- R10: Both FIFOs keep first-in first-out order. A data-port read with the inbound FIFO empty returns 0 and pops nothing.
- R11: irq is high exactly when the global gate is open and at least one enabled status condition is true. The gate is closed by reset and opened by a local enable pulse.
- R12: A write to offset 7 empties both FIFOs and clears both mailbox flags and the global gate. The enable register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode | input | 1 | 1 selects the 16-bit data path, 0 the byte path |
| h_sel | input | 1 | Host access strobe, one cycle per access |
| h_wr | input | 1 | Host access is a write |
| h_word | input | 1 | Host access is 16 bits wide |
| h_addr | input | 3 | Host register offset |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, valid during the access cycle |
| l_push | input | 1 | Local push into the inbound FIFO |
| l_push_data | input | 16 | Entry pushed by the local side |
| l_pop | input | 1 | Local pop from the outbound FIFO |
| l_pop_data | output | 16 | Head of the outbound FIFO |
| l_mb_wr | input | 1 | Local write of the inbound mailbox |
| l_mb_wdata | input | 8 | Inbound mailbox write data |
| l_mb_rd | input | 1 | Local read of the outbound mailbox |
| l_mb_rdata | output | 8 | Outbound mailbox contents |
| l_irq_en | input | 1 | Pulse that opens the global interrupt gate |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench sweeps every fill level, from empty to one past full, in both data widths and for both directions. It compares the full status byte at each step. A design with the wrong capacity, or with half-full thresholds that do not scale with the mode, shows a wrong bit at the boundary. A design that accepts an overflow push shows a changed pop sequence. The mailbox sequences check that a readback with the select bit set neither clears the outbound flag nor consumes the inbound message. They also check that the low two bits read zero. A design that clears on any read, or stores all eight bits, fails there. The interrupt checks step through each enable bit and the two reserved bits, before and after the gate opens and across a board reset. This catches a gate that survives the reset, or an enable register that is wiped by it.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
   // host register offsets (decoded by the host driver)
   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_STAT = 3'd2;
   localparam logic [2:0] OFS_MBOX = 3'd3;
   localparam logic [2:0] OFS_BRST = 3'd7;

   // status bit positions
   localparam int SB_OMB    = 7;
   localparam int SB_OFULL  = 6;
   localparam int SB_IEMPTY = 5;
   localparam int SB_OHALF  = 4;
   localparam int SB_IHALF  = 3;
   localparam int SB_IMB    = 2;
   localparam int SB_IFULL  = 1;
   localparam int SB_OEMPTY = 0;

   // enable register bit positions
   localparam int EB_RSEL   = 7;
   localparam int EB_IMB    = 6;
   localparam int EB_IFULL  = 5;
   localparam int EB_IEMPTY = 3;
   localparam int EB_OFULL  = 2;
   localparam int EB_OEMPTY = 0;
   localparam logic [7:0] EN_WRITABLE = 8'hED;

   // direction index for the replicated FIFO and mailbox instances
   localparam int DIR_IN  = 0;
   localparam int DIR_OUT = 1;
   localparam int NDIR    = 2;

   localparam int NIRQ = 5;

   typedef struct packed {
      logic full;
      logic half;
      logic empty;
   } lvl_t;
endpackage

// File: rtl/mbf_fifo.sv
module mbf_fifo #(
   parameter int AW = 4,
   parameter int W  = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [AW:0]   cap,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output mbf_pkg::lvl_t lvl
);
   localparam int DEPTH = 1 << AW;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign lvl.full  = (cnt >= cap);
   assign lvl.half  = (cnt >= (cap >> 1));
   assign lvl.empty = (cnt == '0);

   assign do_push = push & ~lvl.full;
   assign do_pop  = pop & ~lvl.empty;
   assign rdata   = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp] <= wdata;
   end
endmodule

// File: rtl/mbf_mailbox.sv
module mbf_mailbox #(
   parameter int MB_BITS = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  logic       take,
   output logic [7:0] q,
   output logic       full
);
   localparam logic [7:0] KEEP = 8'hFF << (8 - MB_BITS);

   logic [7:0] val;

   assign q = val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val  <= '0;
         full <= 1'b0;
      end else if (clr) begin
         val  <= '0;
         full <= 1'b0;
      end else if (wr) begin
         val  <= wdata & KEEP;
         full <= 1'b1;
      end else if (take) begin
         full <= 1'b0;
      end
   end
endmodule

// File: rtl/mbf_irq.sv
module mbf_irq #(
   parameter int N = 5
) (
   input  logic         gate,
   input  logic [N-1:0] en,
   input  logic [N-1:0] cond,
   output logic         irq
);
   logic [N-1:0] hit;

   for (genvar i = 0; i < N; i++) begin : g_term
      assign hit[i] = en[i] & cond[i];
   end

   assign irq = gate & (|hit);
endmodule

// File: rtl/mbf_host_if.sv
module mbf_host_if #(
   parameter int AW      = 4,
   parameter int MB_BITS = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        word_mode,
   input  logic        h_sel,
   input  logic        h_wr,
   input  logic        h_word,
   input  logic [2:0]  h_addr,
   input  logic [15:0] h_wdata,
   output logic [15:0] h_rdata,
   input  logic        l_push,
   input  logic [15:0] l_push_data,
   input  logic        l_pop,
   output logic [15:0] l_pop_data,
   input  logic        l_mb_wr,
   input  logic [7:0]  l_mb_wdata,
   input  logic        l_mb_rd,
   output logic [7:0]  l_mb_rdata,
   input  logic        l_irq_en,
   output logic        irq
);
   import mbf_pkg::*;

   localparam int          DEPTH    = 1 << AW;
   localparam logic [AW:0] CAP_WORD = (AW+1)'(DEPTH);
   localparam logic [AW:0] CAP_BYTE = (AW+1)'(DEPTH / 2);

   if (AW < 2 || AW > 12) begin : g_bad_aw
      $error("mbf_host_if: AW must lie in 2..12");
   end
   if (MB_BITS < 1 || MB_BITS > 8) begin : g_bad_mb
      $error("mbf_host_if: MB_BITS must lie in 1..8");
   end

   // host access decode
   logic hw, hr, brd_rst, wide;
   assign hw      = h_sel & h_wr;
   assign hr      = h_sel & ~h_wr;
   assign brd_rst = hw && (h_addr == OFS_BRST);
   assign wide    = word_mode & h_word;

   // enable register and global gate
   logic [7:0] mask_q;
   logic       glob_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mask_q <= '0;
      else if (hw && h_addr == OFS_STAT)   mask_q <= h_wdata[7:0] & EN_WRITABLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        glob_en <= 1'b0;
      else if (brd_rst)  glob_en <= 1'b0;
      else if (l_irq_en) glob_en <= 1'b1;
   end

   // FIFOs, one per direction
   logic [AW:0]  cap;
   logic [15:0]  f_wd   [NDIR];
   logic [15:0]  f_q    [NDIR];
   logic         f_push [NDIR];
   logic         f_pop  [NDIR];
   lvl_t         f_lvl  [NDIR];

   assign cap = word_mode ? CAP_WORD : CAP_BYTE;

   assign f_push[DIR_IN]  = l_push;
   assign f_wd[DIR_IN]    = word_mode ? l_push_data : {8'h00, l_push_data[7:0]};
   assign f_pop[DIR_IN]   = hr && (h_addr == OFS_DATA);
   assign f_push[DIR_OUT] = hw && (h_addr == OFS_DATA);
   assign f_wd[DIR_OUT]   = wide ? h_wdata : {8'h00, h_wdata[7:0]};
   assign f_pop[DIR_OUT]  = l_pop;

   for (genvar d = 0; d < NDIR; d++) begin : g_fifo
      mbf_fifo #(.AW(AW), .W(16)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (brd_rst),
         .cap   (cap),
         .push  (f_push[d]),
         .wdata (f_wd[d]),
         .pop   (f_pop[d]),
         .rdata (f_q[d]),
         .lvl   (f_lvl[d])
      );
   end

   // mailboxes, one per direction
   logic       m_wr   [NDIR];
   logic [7:0] m_wd   [NDIR];
   logic       m_take [NDIR];
   logic [7:0] m_q    [NDIR];
   logic       m_full [NDIR];

   assign m_wr[DIR_IN]    = l_mb_wr;
   assign m_wd[DIR_IN]    = l_mb_wdata;
   assign m_take[DIR_IN]  = hr && (h_addr == OFS_MBOX) && !mask_q[EB_RSEL];
   assign m_wr[DIR_OUT]   = hw && (h_addr == OFS_MBOX);
   assign m_wd[DIR_OUT]   = h_wdata[7:0];
   assign m_take[DIR_OUT] = l_mb_rd;

   for (genvar d = 0; d < NDIR; d++) begin : g_mbox
      mbf_mailbox #(.MB_BITS(MB_BITS)) u_mbox (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (brd_rst),
         .wr    (m_wr[d]),
         .wdata (m_wd[d]),
         .take  (m_take[d]),
         .q     (m_q[d]),
         .full  (m_full[d])
      );
   end

   // status assembly
   logic [7:0] st;
   always_comb begin
      st             = '0;
      st[SB_OMB]     = m_full[DIR_OUT];
      st[SB_OFULL]   = f_lvl[DIR_OUT].full;
      st[SB_IEMPTY]  = f_lvl[DIR_IN].empty;
      st[SB_OHALF]   = f_lvl[DIR_OUT].half;
      st[SB_IHALF]   = f_lvl[DIR_IN].half;
      st[SB_IMB]     = m_full[DIR_IN];
      st[SB_IFULL]   = f_lvl[DIR_IN].full;
      st[SB_OEMPTY]  = f_lvl[DIR_OUT].empty;
   end

   // host read mux
   always_comb begin
      h_rdata = '0;
      if (hr) begin
         unique case (h_addr)
            OFS_DATA: if (!f_lvl[DIR_IN].empty)
                         h_rdata = wide ? f_q[DIR_IN] : {8'h00, f_q[DIR_IN][7:0]};
            OFS_STAT: h_rdata = {8'h00, st};
            OFS_MBOX: h_rdata = {8'h00, mask_q[EB_RSEL] ? m_q[DIR_OUT] : m_q[DIR_IN]};
            default:  h_rdata = '0;
         endcase
      end
   end

   assign l_pop_data = f_q[DIR_OUT];
   assign l_mb_rdata = m_q[DIR_OUT];

   // interrupt combine
   logic [NIRQ-1:0] irq_en, irq_cond;
   assign irq_en   = {mask_q[EB_IMB], mask_q[EB_IFULL], mask_q[EB_IEMPTY],
                      mask_q[EB_OFULL], mask_q[EB_OEMPTY]};
   assign irq_cond = {st[SB_IMB], st[SB_IFULL], st[SB_IEMPTY],
                      st[SB_OFULL], st[SB_OEMPTY]};

   mbf_irq #(.N(NIRQ)) u_irq (
      .gate (glob_en),
      .en   (irq_en),
      .cond (irq_cond),
      .irq  (irq)
   );
endmodule

// File: rtl/mbf_chk.sv
module mbf_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        word_mode,
   input logic        h_sel,
   input logic        h_wr,
   input logic [2:0]  h_addr,
   input logic [15:0] h_rdata,
   input logic        l_push,
   input logic        l_mb_wr,
   input logic        l_mb_rd,
   input logic        irq,
   input logic [7:0]  st,
   input logic [7:0]  mask_q,
   input logic        glob_en
);
   import mbf_pkg::*;

   logic hw, hr;
   assign hw = h_sel & h_wr;
   assign hr = h_sel & ~h_wr;

   // R2: low two mailbox bits never read back set
   p_mb_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hr && h_addr == OFS_MBOX) |-> (h_rdata[1:0] == 2'b00));

   // R3: empty and full flags of one FIFO are exclusive
   p_in_lvl_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(st[SB_IEMPTY] && st[SB_IFULL]));
   p_out_lvl_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(st[SB_OEMPTY] && st[SB_OFULL]));

   // R6: host write sets the unread flag; only a local read clears it
   p_omb_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hw && h_addr == OFS_MBOX) |=> st[SB_OMB]);
   p_omb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st[SB_OMB] && !l_mb_rd && !(hw && h_addr == OFS_BRST)) |=> st[SB_OMB]);
   p_omb_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (l_mb_rd && !(hw && h_addr == OFS_MBOX)) |=> !st[SB_OMB]);

   // R7: host read of the inbound mailbox clears its flag
   p_imb_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hr && h_addr == OFS_MBOX && !mask_q[EB_RSEL] && !l_mb_wr) |=> !st[SB_IMB]);

   // R8: a push into a full inbound FIFO leaves it full
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st[SB_IFULL] && l_push && word_mode && !(hr && h_addr == OFS_DATA)
       && !(hw && h_addr == OFS_BRST)) |=> st[SB_IFULL]);

   // R11: closed gate means no interrupt
   p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en |-> !irq);

   // R12: board reset leaves the board side empty and the gate closed
   p_brd_rst_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (hw && h_addr == OFS_BRST) |=>
         (st[SB_IEMPTY] && st[SB_OEMPTY] && !st[SB_OMB] && !st[SB_IMB] && !glob_en));
endmodule

bind mbf_host_if mbf_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .word_mode (word_mode),
   .h_sel     (h_sel),
   .h_wr      (h_wr),
   .h_addr    (h_addr),
   .h_rdata   (h_rdata),
   .l_push    (l_push),
   .l_mb_wr   (l_mb_wr),
   .l_mb_rd   (l_mb_rd),
   .irq       (irq),
   .st        (st),
   .mask_q    (mask_q),
   .glob_en   (glob_en)
);

// File: tb/sim_mbf_host_if.sv
module sim_mbf_host_if;
   localparam int AW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        word_mode = 1'b1;
   logic        h_sel = 1'b0, h_wr = 1'b0, h_word = 1'b0;
   logic [2:0]  h_addr = '0;
   logic [15:0] h_wdata = '0;
   logic [15:0] h_rdata;
   logic        l_push = 1'b0, l_pop = 1'b0, l_mb_wr = 1'b0, l_mb_rd = 1'b0, l_irq_en = 1'b0;
   logic [15:0] l_push_data = '0;
   logic [15:0] l_pop_data;
   logic [7:0]  l_mb_wdata = '0;
   logic [7:0]  l_mb_rdata;
   logic        irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mbf_host_if #(.AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
      .h_sel(h_sel), .h_wr(h_wr), .h_word(h_word), .h_addr(h_addr),
      .h_wdata(h_wdata), .h_rdata(h_rdata),
      .l_push(l_push), .l_push_data(l_push_data),
      .l_pop(l_pop), .l_pop_data(l_pop_data),
      .l_mb_wr(l_mb_wr), .l_mb_wdata(l_mb_wdata),
      .l_mb_rd(l_mb_rd), .l_mb_rdata(l_mb_rdata),
      .l_irq_en(l_irq_en), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic hacc(input logic wr, input logic [2:0] a, input logic wd,
                       input logic [15:0] d, output logic [15:0] q);
      @(negedge clk);
      h_sel = 1'b1; h_wr = wr; h_addr = a; h_word = wd; h_wdata = d;
      #1 q = h_rdata;
      @(posedge clk);
      #1 h_sel = 1'b0; h_wr = 1'b0;
   endtask

   task automatic hwr(input logic [2:0] a, input logic wd, input logic [15:0] d);
      logic [15:0] x;
      hacc(1'b1, a, wd, d, x);
   endtask

   task automatic hrd(input logic [2:0] a, input logic wd, output logic [15:0] q);
      hacc(1'b0, a, wd, 16'h0, q);
   endtask

   task automatic rdstat(output logic [7:0] s);
      logic [15:0] q;
      hrd(3'd2, 1'b0, q);
      s = q[7:0];
   endtask

   task automatic lpush(input logic [15:0] d);
      @(negedge clk); l_push = 1'b1; l_push_data = d;
      @(posedge clk); #1 l_push = 1'b0;
   endtask

   task automatic lpop(output logic [15:0] q);
      @(negedge clk); #1 q = l_pop_data; l_pop = 1'b1;
      @(posedge clk); #1 l_pop = 1'b0;
   endtask

   task automatic lmbwr(input logic [7:0] d);
      @(negedge clk); l_mb_wr = 1'b1; l_mb_wdata = d;
      @(posedge clk); #1 l_mb_wr = 1'b0;
   endtask

   task automatic lmbrd(output logic [7:0] q);
      @(negedge clk); #1 q = l_mb_rdata; l_mb_rd = 1'b1;
      @(posedge clk); #1 l_mb_rd = 1'b0;
   endtask

   task automatic lgate();
      @(negedge clk); l_irq_en = 1'b1;
      @(posedge clk); #1 l_irq_en = 1'b0;
   endtask

   function automatic logic [15:0] pat(input int k);
      return {8'(k * 7 + 3), 8'(k * 13 + 1)};
   endfunction

   function automatic logic [7:0] est(input int ob, input int ib, input int cap,
                                      input bit omb, input bit imb);
      return {omb, ob >= cap, ib == 0, ob >= cap / 2, ib >= cap / 2, imb, ib >= cap, ob == 0};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0]  s, mb;
      logic [15:0] q;
      int cap, n;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state: R3, R11, R10
      rdstat(s);      chk("R3 reset status", s, 8'h21);
      chk("R11 reset irq", irq, 1'b0);
      hrd(3'd0, 1'b1, q); chk("R10 empty read", q, 16'h0);
      rdstat(s);      chk("R10 empty read pops nothing", s, 8'h21);

      // fill-level sweeps in both widths: R8, R3, R9, R10
      for (int m = 1; m >= 0; m--) begin
         @(negedge clk) word_mode = m[0];
         hwr(3'd7, 1'b0, 16'h0);
         cap = (m == 1) ? (1 << AW) : (1 << (AW - 1));
         for (int k = 1; k <= cap + 1; k++) begin
            hwr(3'd0, m[0], pat(k));
            n = (k > cap) ? cap : k;
            rdstat(s); chk("R8 outbound level status", s, est(n, 0, cap, 0, 0));
         end
         for (int k = 1; k <= cap; k++) begin
            lpop(q);
            chk("R10 outbound order", q, (m == 1) ? pat(k) : {8'h00, pat(k)[7:0]});
         end
         rdstat(s); chk("R8 outbound drained", s, 8'h21);
         for (int k = 1; k <= cap + 1; k++) begin
            lpush(pat(k) ^ 16'h8080);
            n = (k > cap) ? cap : k;
            rdstat(s); chk("R3 inbound level status", s, est(0, n, cap, 0, 0));
         end
         for (int k = 1; k <= cap; k++) begin
            hrd(3'd0, m[0], q);
            chk("R9 inbound data width", q,
                (m == 1) ? (pat(k) ^ 16'h8080) : {8'h00, pat(k)[7:0] ^ 8'h80});
         end
         rdstat(s); chk("R8 inbound drained, overflow dropped", s, 8'h21);
      end

      // mailboxes: R2, R5, R6, R7
      @(negedge clk) word_mode = 1'b1;
      hwr(3'd7, 1'b0, 16'h0);
      hwr(3'd3, 1'b0, 16'h00FF);
      rdstat(s);      chk("R6 host write sets unread", s, 8'hA1);
      hwr(3'd2, 1'b0, 16'h0080);
      hrd(3'd3, 1'b0, q); chk("R5 R2 outbound readback", q, 16'h00FC);
      rdstat(s);      chk("R6 readback keeps unread", s, 8'hA1);
      lmbwr(8'hA7);
      rdstat(s);      chk("R7 local write sets inbound flag", s, 8'hA5);
      hrd(3'd3, 1'b0, q); chk("R5 select picks outbound", q, 16'h00FC);
      rdstat(s);      chk("R5 inbound flag untouched", s, 8'hA5);
      lmbrd(mb);      chk("R2 local sees six bits", mb, 8'hFC);
      rdstat(s);      chk("R6 local read clears unread", s, 8'h25);
      hwr(3'd2, 1'b0, 16'h0000);
      hrd(3'd3, 1'b0, q); chk("R2 R7 inbound read", q, 16'h00A4);
      rdstat(s);      chk("R7 host read clears inbound flag", s, 8'h21);

      // interrupt enables: R4, R11
      hwr(3'd2, 1'b0, 16'h0008);
      chk("R11 gate closed", irq, 1'b0);
      lgate();
      chk("R11 gate open inbound empty", irq, 1'b1);
      hwr(3'd2, 1'b0, 16'h0012); chk("R4 reserved bits inert", irq, 1'b0);
      hwr(3'd2, 1'b0, 16'h0064); chk("R4 false conditions", irq, 1'b0);
      hwr(3'd2, 1'b0, 16'h0001); chk("R4 outbound empty enable", irq, 1'b1);
      hwr(3'd2, 1'b0, 16'h0040); chk("R4 mailbox enable idle", irq, 1'b0);
      lmbwr(8'h10);              chk("R4 inbound mailbox irq", irq, 1'b1);
      hrd(3'd3, 1'b0, q);        chk("R7 read drops irq", irq, 1'b0);

      // board reset: R12
      hwr(3'd2, 1'b0, 16'h0008);
      lpush(16'h0001); hwr(3'd0, 1'b1, 16'h0005); lmbwr(8'h04); hwr(3'd3, 1'b0, 16'h0008);
      rdstat(s);      chk("R12 pre-reset status", s, 8'h84);
      hwr(3'd7, 1'b0, 16'h0);
      rdstat(s);      chk("R12 board reset clears", s, 8'h21);
      chk("R12 gate closed", irq, 1'b0);
      lgate();
      chk("R12 enable register kept", irq, 1'b1);

      // offsets and word-mode byte read: R1, R9, R10
      lpush(16'h3344);
      hrd(3'd7, 1'b0, q); chk("R1 offset 7 read", q, 16'h0);
      rdstat(s);      chk("R1 offset 7 read no effect", s, 8'h01);
      hwr(3'd1, 1'b0, 16'h0055);
      rdstat(s);      chk("R1 offset 1 byte write ignored", s, 8'h01);
      hrd(3'd0, 1'b1, q); chk("R10 word read", q, 16'h3344);
      lpush(16'hBEEF); lpush(16'h1234);
      hrd(3'd0, 1'b0, q); chk("R9 byte read low byte", q, 16'h00EF);
      hrd(3'd0, 1'b1, q); chk("R9 byte read consumed entry", q, 16'h1234);
      rdstat(s);      chk("R9 drained", s, 8'h21);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule